// File: doc/BRIEF.md
# Byte-Interleaved Component Video Demultiplexer

This block takes 4:2:2 component video arriving as 8-bit bytes on a clock that runs at twice the pixel rate and turns it into whole pixels. Each pixel has one luma sample and the Cb/Cr pair it shares with its neighbour. The pixels leave on a valid/ready stream. The block has two input arrangements. In the single-port arrangement, port A carries a byte stream that repeats Cb, Y, Cr, Y. In the split arrangement, port A carries luma and port B carries chroma that alternates Cb, Cr.

When the block acts as a timing slave in the single-port arrangement, it can also look for embedded timing codes in the byte stream. Each code is a four-byte group: FF, 00, 00, then a status byte. The block takes the horizontal, vertical and field flags from the status byte, realigns its sample phase at the start of each active line, and passes only active-line samples. A qualifier input marks the clock cycles on which the ports carry a byte.

The output stream cannot slow down the source, because video has no flow control. A pixel that is waiting stays on the outputs with its data unchanged until `out_ready` takes it. If the next pixel finishes first, the next pixel replaces it.

Top module: `vid_demux`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises, `out_valid` is 0, `flag_h` is 1, `flag_v` is 1 and `flag_f` is 0.
- R2: Single-port mode (`dual_port`=0), with code decoding inactive: accepted bytes on `port_a` are taken in the order Cb, Y0, Cr, Y1, and the first byte after reset is Cb. The pixel (Y0,Cb,Cr) appears on the edge that accepts Cr. The pixel (Y1,Cb,Cr) appears on the edge that accepts Y1.
- R3: A byte is accepted only on a clock edge where `in_qual` is 1. Cycles where `in_qual` is 0 change no sample and produce no pixel.
- R4: Split mode (`dual_port`=1): each qualified edge takes luma from `port_a` and chroma from `port_b`, and the chroma alternates Cb then Cr, starting with Cb after reset. The pixel (Y0,Cb,Cr) appears on the edge that takes Cr. The pixel (Y1,Cb,Cr) appears on the next clock edge.
- R5: A pixel stays presented, with `out_valid`=1 and stable data, until `out_ready` is 1 at an edge. If a new pixel finishes while the old one is still presented, the new one replaces it.
- R6: Code decoding is active only when `slave_en`=1, `trs_en`=1 and `dual_port`=0. When it is inactive, FF/00 bytes are ordinary samples and the flags do not change.
- R7: When decoding is active, the byte that follows FF,00,00 is the status byte. Its bit 7 must be 1, bit 6 is F, bit 5 is V and bit 4 is H. Bits 3:0 must equal {V^H, F^H, F^V, F^V^H}. A status byte that passes these checks loads the three flags on the edge that accepts it.
- R8: A status byte whose bit 7 is 0, or whose bits 3:0 do not match, leaves all three flags unchanged.
- R9: A valid status byte with H=0 (start of active line) resets the sample phase, so the next accepted byte is taken as Cb.
- R10: While decoding is active, no pixel is produced while `flag_h`=1. No pixel is produced from any of the four bytes that begin with an FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| dual_port | input | 1 | 0: interleaved bytes on port A; 1: luma on A, chroma on B |
| slave_en | input | 1 | Block runs as a timing slave |
| trs_en | input | 1 | Enable decoding of embedded timing codes |
| in_qual | input | 1 | Marks cycles on which the ports carry a byte |
| port_a | input | 8 | Interleaved bytes, or luma in split mode |
| port_b | input | 8 | Alternating Cb/Cr in split mode |
| out_ready | input | 1 | Downstream takes the presented pixel |
| out_valid | output | 1 | A pixel is presented |
| out_y | output | 8 | Luma of the presented pixel |
| out_cb | output | 8 | Cb of the presented pixel |
| out_cr | output | 8 | Cr of the presented pixel |
| flag_h | output | 1 | Horizontal blanking flag from the last valid code |
| flag_v | output | 1 | Vertical blanking flag from the last valid code |
| flag_f | output | 1 | Field flag from the last valid code |

## Verification
The bench goes after these failure cases:
- A stray byte before a start-of-line code shifts the phase. A design that does not realign would swap luma and chroma for the whole line.
- Every flag combination is sent with a correct code. Every protection bit, and the marker bit, is then flipped in turn. A design that trusts a damaged code would change its flags.
- The four bytes of an end-of-line code fall inside active video. A design that passes them through would emit a pixel built from FF and 00.
- In split mode, the second pixel of each pair is checked under both a sparse and a dense qualifier. A design that drops or delays it would miscompare.

// File: rtl/vid_demux_pkg.sv
package vid_demux_pkg;

  // Position of the four samples within one single-port group
  typedef enum logic [1:0] {
    SLOT_CB = 2'd0,
    SLOT_Y0 = 2'd1,
    SLOT_CR = 2'd2,
    SLOT_Y1 = 2'd3
  } slot_t;

  // Bit positions inside the timing status byte
  localparam int XY_MARK = 7;
  localparam int XY_F    = 6;
  localparam int XY_V    = 5;
  localparam int XY_H    = 4;
  localparam int XY_PW   = 4;

  // Number of bytes in a timing code after its leading all-ones byte
  localparam int CODE_TAIL = 3;

  function automatic logic [XY_PW-1:0] code_prot(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vid_trs_detect.sv
module vid_trs_detect
  import vid_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic              flag_h,
  output logic              flag_v,
  output logic              flag_f,
  output logic              sav,
  output logic              skip
);
  localparam int HIST_N = CODE_TAIL;
  localparam int CNT_W  = $clog2(CODE_TAIL + 1);
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0]  TAIL = CNT_W'(CODE_TAIL);

  logic [HIST_N-1:0][DATA_W-1:0] hist;
  logic [CNT_W-1:0]              hold_cnt;
  logic                          preamble, xy_ok, hit;

  // Oldest byte must be all ones, the rest all zeros
  always_comb begin
    preamble = (hist[HIST_N-1] == ONES);
    for (int i = 0; i < HIST_N - 1; i++) begin
      if (hist[i] != ZERO) preamble = 1'b0;
    end
  end

  assign xy_ok = din[XY_MARK] &&
                 (din[XY_PW-1:0] == code_prot(din[XY_F], din[XY_V], din[XY_H]));
  assign hit   = en && take && preamble && xy_ok;
  assign sav   = hit && !din[XY_H];
  assign skip  = en && ((hold_cnt != '0) || (din == ONES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist     <= '0;
      hold_cnt <= '0;
      flag_h   <= 1'b1;
      flag_v   <= 1'b1;
      flag_f   <= 1'b0;
    end else begin
      if (take) hist <= {hist[HIST_N-2:0], din};
      if (en && take) begin
        if (hold_cnt != '0)    hold_cnt <= hold_cnt - 1'b1;
        else if (din == ONES)  hold_cnt <= TAIL;
      end
      if (hit) begin
        flag_h <= din[XY_H];
        flag_v <= din[XY_V];
        flag_f <= din[XY_F];
      end
    end
  end
endmodule

// File: rtl/vid_pix_asm.sv
module vid_pix_asm
  import vid_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual,
  input  logic              take,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sav,
  input  logic              skip,
  input  logic              gate_ok,
  output logic              load,
  output logic [DATA_W-1:0] py,
  output logic [DATA_W-1:0] pcb,
  output logic [DATA_W-1:0] pcr
);
  slot_t             slot;
  logic              chroma_odd, pend;
  logic [DATA_W-1:0] cb_t, y0_t, cr_t, y1_t;

  always_comb begin
    load = 1'b0;
    py   = y0_t;
    pcb  = cb_t;
    pcr  = cr_t;
    if (dual) begin
      if (pend) begin
        load = 1'b1;
        py   = y1_t;
      end else if (take && chroma_odd) begin
        load = 1'b1;
        pcr  = b;
      end
    end else if (take && !skip && gate_ok) begin
      case (slot)
        SLOT_CR: begin load = 1'b1; pcr = a; end
        SLOT_Y1: begin load = 1'b1; py  = a; end
        default: load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot       <= SLOT_CB;
      chroma_odd <= 1'b0;
      pend       <= 1'b0;
      cb_t       <= '0;
      y0_t       <= '0;
      cr_t       <= '0;
      y1_t       <= '0;
    end else if (dual) begin
      pend <= take && chroma_odd;
      if (take) begin
        chroma_odd <= !chroma_odd;
        if (!chroma_odd) begin
          cb_t <= b;
          y0_t <= a;
        end else begin
          cr_t <= b;
          y1_t <= a;
        end
      end
    end else begin
      pend <= 1'b0;
      if (take) begin
        slot <= sav ? SLOT_CB : slot_t'(slot + 2'd1);
        case (slot)
          SLOT_CB: cb_t <= a;
          SLOT_Y0: y0_t <= a;
          SLOT_CR: cr_t <= a;
          default: y1_t <= a;
        endcase
      end
    end
  end
endmodule

// File: rtl/vid_out_stage.sv
module vid_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_y,
  input  logic [DATA_W-1:0] in_cb,
  input  logic [DATA_W-1:0] in_cr,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] out_y,
  output logic [DATA_W-1:0] out_cb,
  output logic [DATA_W-1:0] out_cr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      out_y  <= '0;
      out_cb <= '0;
      out_cr <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      out_y  <= in_y;
      out_cb <= in_cb;
      out_cr <= in_cr;
    end else if (ready) begin
      valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_demux.sv
module vid_demux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_port,
  input  logic              slave_en,
  input  logic              trs_en,
  input  logic              in_qual,
  input  logic [DATA_W-1:0] port_a,
  input  logic [DATA_W-1:0] port_b,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_y,
  output logic [DATA_W-1:0] out_cb,
  output logic [DATA_W-1:0] out_cr,
  output logic              flag_h,
  output logic              flag_v,
  output logic              flag_f
);
  logic              decode_on, gate_ok, sav, skip, load;
  logic [DATA_W-1:0] asm_y, asm_cb, asm_cr;

  assign decode_on = slave_en && trs_en && !dual_port;
  assign gate_ok   = !decode_on || !flag_h;

  vid_trs_detect #(.DATA_W(DATA_W)) u_trs (
    .clk(clk), .rst_n(rst_n), .en(decode_on), .take(in_qual), .din(port_a),
    .flag_h(flag_h), .flag_v(flag_v), .flag_f(flag_f), .sav(sav), .skip(skip)
  );

  vid_pix_asm #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .dual(dual_port), .take(in_qual),
    .a(port_a), .b(port_b), .sav(sav), .skip(skip), .gate_ok(gate_ok),
    .load(load), .py(asm_y), .pcb(asm_cb), .pcr(asm_cr)
  );

  vid_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_y(asm_y), .in_cb(asm_cb), .in_cr(asm_cr), .ready(out_ready),
    .valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );
endmodule

// File: rtl/vid_demux_sva.sv
module vid_demux_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dual_port,
  input logic              slave_en,
  input logic              trs_en,
  input logic              in_qual,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_y,
  input logic [DATA_W-1:0] out_cb,
  input logic [DATA_W-1:0] out_cr,
  input logic              flag_h,
  input logic              flag_v,
  input logic              flag_f
);
  logic decode_on;
  assign decode_on = slave_en && trs_en && !dual_port;

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && flag_h && flag_v && !flag_f));

  p_hold_pixel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !in_qual && !dual_port)
      |=> (out_valid && $stable(out_y) && $stable(out_cb) && $stable(out_cr)));

  p_no_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  p_flags_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !decode_on |=> ($stable(flag_h) && $stable(flag_v) && $stable(flag_f)));

  p_blank_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_on && flag_h && !out_valid) |=> !out_valid);

  p_idle_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_qual && !dual_port && !out_valid) |=> !out_valid);
endmodule

bind vid_demux vid_demux_sva #(.DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .dual_port(dual_port), .slave_en(slave_en),
  .trs_en(trs_en), .in_qual(in_qual), .out_ready(out_ready),
  .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr),
  .flag_h(flag_h), .flag_v(flag_v), .flag_f(flag_f)
);

// File: tb/vid_demux_test.sv
module vid_demux_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dual_port = 1'b0, slave_en = 1'b0, trs_en = 1'b0, in_qual = 1'b0;
  logic [7:0] port_a = '0, port_b = '0;
  logic       out_ready = 1'b1;
  logic       out_valid, flag_h, flag_v, flag_f;
  logic [7:0] out_y, out_cb, out_cr;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vid_demux uut (
    .clk(clk), .rst_n(rst_n), .dual_port(dual_port), .slave_en(slave_en),
    .trs_en(trs_en), .in_qual(in_qual), .port_a(port_a), .port_b(port_b),
    .out_ready(out_ready), .out_valid(out_valid), .out_y(out_y),
    .out_cb(out_cb), .out_cr(out_cr), .flag_h(flag_h), .flag_v(flag_v),
    .flag_f(flag_f)
  );

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] b, input logic q);
    port_a  = a;
    port_b  = b;
    in_qual = q;
    @(negedge clk);
  endtask

  task automatic chk_pix(input string req, input logic [7:0] y, input logic [7:0] cb, input logic [7:0] cr);
    chk(out_valid && out_y == y && out_cb == cb && out_cr == cr, req,
        {7'd0, out_valid, out_y, out_cb, out_cr}, {8'd1, y, cb, cr});
  endtask

  task automatic chk_nv(input string req);
    chk(!out_valid, req, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic chk_flags(input string req, input logic h, input logic v, input logic f);
    chk({flag_h, flag_v, flag_f} == {h, v, f}, req,
        {29'd0, flag_h, flag_v, flag_f}, {29'd0, h, v, f});
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    in_qual = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] cb, y0, cr, y1, good;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk_nv("R1");
    chk_flags("R1", 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;

    // R2, R3: single-port sweep, qualifier gaps on odd groups
    for (int n = 0; n < 48; n++) begin
      cb = 8'(n * 5); y0 = 8'(n * 5 + 1); cr = 8'(n * 5 + 2); y1 = 8'(n * 5 + 3);
      put(cb, 8'h00, 1'b1); chk_nv("R2");
      put(y0, 8'h00, 1'b1);
      if (n % 2 == 1) begin
        put(8'hAA, 8'h55, 1'b0); chk_nv("R3");
      end
      put(cr, 8'h00, 1'b1); chk_pix("R2", y0, cb, cr);
      if (n % 2 == 1) begin
        put(8'hEE, 8'h11, 1'b0); chk_nv("R3");
      end
      put(y1, 8'h00, 1'b1); chk_pix("R2", y1, cb, cr);
    end

    // R5: hold under back-pressure, then overwrite
    out_ready = 1'b0;
    put(8'h21, 0, 1); put(8'h22, 0, 1); put(8'h23, 0, 1);
    chk_pix("R5", 8'h22, 8'h21, 8'h23);
    put(8'h99, 0, 0); chk_pix("R5", 8'h22, 8'h21, 8'h23);
    put(8'h98, 0, 0); chk_pix("R5", 8'h22, 8'h21, 8'h23);
    put(8'h24, 0, 1); chk_pix("R5", 8'h24, 8'h21, 8'h23);
    out_ready = 1'b1;
    put(8'h00, 0, 0); chk_nv("R5");

    // R4: split mode, sparse then dense qualifier
    do_reset();
    dual_port = 1'b1;
    for (int n = 0; n < 32; n++) begin
      y0 = 8'(n * 7); cb = 8'(n * 7 + 1); y1 = 8'(n * 7 + 2); cr = 8'(n * 7 + 3);
      if (n < 16) begin
        put(y0, cb, 1'b1); chk_nv("R4");
        put(8'h55, 8'h55, 1'b0);
        put(y1, cr, 1'b1); chk_pix("R4", y0, cb, cr);
        put(8'h66, 8'h66, 1'b0); chk_pix("R4", y1, cb, cr);
      end else begin
        put(y0, cb, 1'b1);
        if (n == 16) chk_nv("R4");
        else chk_pix("R4", 8'((n - 1) * 7 + 2), 8'((n - 1) * 7 + 1), 8'((n - 1) * 7 + 3));
        put(y1, cr, 1'b1); chk_pix("R4", y0, cb, cr);
      end
    end
    put(8'h00, 8'h00, 1'b0); chk_pix("R4", 8'(31 * 7 + 2), 8'(31 * 7 + 1), 8'(31 * 7 + 3));

    // R6: codes pass as data when not a slave
    do_reset();
    dual_port = 1'b0; slave_en = 1'b0; trs_en = 1'b1;
    put(8'hFF, 0, 1); put(8'h00, 0, 1); put(8'h00, 0, 1);
    chk_pix("R6", 8'h00, 8'hFF, 8'h00);
    put(xy(0, 0, 0), 0, 1);
    chk_pix("R6", xy(0, 0, 0), 8'hFF, 8'h00);
    chk_flags("R6", 1'b1, 1'b1, 1'b0);

    // R7, R10: every flag combination through valid codes
    do_reset();
    slave_en = 1'b1;
    put(8'h12, 0, 1); chk_nv("R10");
    for (int k = 0; k < 8; k++) begin
      put(8'hFF, 0, 1); chk_nv("R10");
      put(8'h00, 0, 1); chk_nv("R10");
      put(8'h00, 0, 1); chk_nv("R10");
      put(xy(k[2], k[1], k[0]), 0, 1); chk_nv("R10");
      chk_flags("R7", k[0], k[1], k[2]);
    end

    // R8: damaged status bytes leave flags at h=1 v=1 f=1
    good = xy(0, 0, 0);
    for (int j = 0; j < 5; j++) begin
      put(8'hFF, 0, 1); put(8'h00, 0, 1); put(8'h00, 0, 1);
      put(good ^ ((j == 4) ? 8'h80 : 8'(1 << j)), 0, 1);
      chk_flags("R8", 1'b1, 1'b1, 1'b1);
    end

    // R9: stray byte, then start of line realigns phase
    put(8'h33, 0, 1);
    put(8'hFF, 0, 1); put(8'h00, 0, 1); put(8'h00, 0, 1); put(good, 0, 1);
    chk_flags("R7", 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 4; n++) begin
      cb = 8'(8'h40 + n * 4); y0 = cb + 8'd1; cr = cb + 8'd2; y1 = cb + 8'd3;
      put(cb, 0, 1); chk_nv("R9");
      put(y0, 0, 1);
      put(cr, 0, 1); chk_pix("R9", y0, cb, cr);
      put(y1, 0, 1); chk_pix("R9", y1, cb, cr);
    end

    // R10: end-of-line code inside active video, then blanking
    put(8'hFF, 0, 1); chk_nv("R10");
    put(8'h00, 0, 1); chk_nv("R10");
    put(8'h00, 0, 1); chk_nv("R10");
    put(xy(0, 0, 1), 0, 1); chk_nv("R10");
    chk_flags("R7", 1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 4; n++) begin
      put(8'(8'h70 + n), 0, 1); chk_nv("R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule